// File: doc/BRIEF.md
# Two-Stage Divided Clock-Enable Generator

This block turns one of four source clock-enable streams into a slower peripheral strobe. All logic runs on a single fast clock. Each source is a one-cycle enable pulse on that clock, and the output is also a one-cycle enable pulse rather than a derived clock. The path has three stages in order:

- a 4:1 source selector;
- a divide stage whose ratio is the product of two 3-bit factors;
- a registered gate that is controlled by a disable bit.

Software programs the block through a small word-addressed register bank with a plain write strobe and a combinational read port. A field value of 7 is treated as invalid. A zero or invalid factor stalls the output and never causes a division by zero. Reconfiguration is deferred to the end of the current output period, so a change of settings never produces a shortened interval between strobes. A bypass bit passes every selected source pulse straight through to the gate.

Top module: `clkdiv_gen`

## Requirements
- R1: Registers sit at byte offsets 0x00 (source), 0x04/0x08/0x0C (divide), 0x10 (bypass) and 0x14 (disable). Only implemented fields store data, all other bits and unmapped offsets read 0. With all ones written, the six offsets read 0x30, 0, 0, 0x7E000, 0x80 and 0x20.
- R2: After reset every register reads 0 except offset 0x14, which reads 0x20 (gate disabled), and the strobe output is low.
- R3: Bits [5:4] of offset 0x00 choose which of the four source enables drives the divider (value n selects src_ce[n]).
- R4: With factor A in bits [18:16] and factor B in bits [15:13] of offset 0x0C, the strobe fires once per A*B pulses of the selected source, one fast cycle wide.
- R5: If either factor is 0 or 7, the strobe stays low.
- R6: Setting bit 5 of offset 0x14 forces the strobe low. Clearing it lets strobes through again, while the divide count keeps running in both states.
- R7: With bit 7 of offset 0x10 set, every selected source pulse yields a strobe, whatever the factors hold.
- R8: New source, factor or bypass settings are applied only when the divide count is at its period boundary. The period in progress completes with the old settings.
- R9: A strobe appears in the fast-clock cycle right after the edge that samples the terminal source pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_ce | input | 4 | Four source clock-enable pulses |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| strobe_o | output | 1 | Divided, gated output enable |

## Verification
The four sources carry different patterns: one pulses every cycle, one every second cycle, one every third cycle, and one is pseudo-random. The spacing between strobes therefore reveals both which source was selected and which ratio is in use. One ratio is run on two sources, so a wrong select shows up as a doubled gap, and ratios of 1, 2 and 6 separate a sum from a product. Invalid and zero factors, bypass and the gate are each checked by counting strobes over a window. A configuration change written right after a strobe must give one old-length gap and then a new-length gap, which tells deferred update apart from immediate update. A behavioural model in the bench is compared against the output on every cycle.

// File: rtl/ckgen_pkg.sv
// Shared constants for the divided clock-enable generator.
// Assumes a 32-bit register bank addressed by byte offset.
package ckgen_pkg;
    localparam int DATA_W = 32;
    localparam int FLD_W  = 3;
    localparam int NREG   = 6;
    localparam logic [FLD_W-1:0] FLD_BAD = '1;

    // Map a raw factor field to its divide value (invalid code becomes 0).
    function automatic logic [FLD_W-1:0] factor_of(input logic [FLD_W-1:0] raw);
        return (raw == FLD_BAD) ? '0 : raw;
    endfunction
endpackage

// File: rtl/ckgen_regs.sv
// Register bank: six word registers, each storing only its implemented
// field bits. Unused bits and unmapped offsets read zero. Assumes writes
// are single-cycle strobes; reads are combinational.
module ckgen_regs
    import ckgen_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int SEL_W   = 2,
    parameter int SRC_LSB = 4,
    parameter int DA_REG  = 2,
    parameter int DA_LSB  = 16,
    parameter int DB_REG  = 2,
    parameter int DB_LSB  = 13,
    parameter int BYP_BIT = 7,
    parameter int DIS_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [SEL_W-1:0]  src_sel,
    output logic [FLD_W-1:0]  fac_a,
    output logic [FLD_W-1:0]  fac_b,
    output logic              bypass,
    output logic              gate_dis
);
    localparam int DIS_IDX = NREG - 1;

    // Bit mask of the fields implemented in register index i.
    function automatic logic [DATA_W-1:0] reg_mask(input int i);
        logic [DATA_W-1:0] m;
        m = '0;
        if (i == 0) m = DATA_W'((2**SEL_W) - 1) << SRC_LSB;
        if (i >= 1 && i <= 3) begin
            if (DA_REG == i - 1) m = m | (DATA_W'(FLD_BAD) << DA_LSB);
            if (DB_REG == i - 1) m = m | (DATA_W'(FLD_BAD) << DB_LSB);
        end
        if (i == 4) m = DATA_W'(1) << BYP_BIT;
        if (i == DIS_IDX) m = DATA_W'(1) << DIS_BIT;
        return m;
    endfunction

    logic [DATA_W-1:0] regs_w [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = reg_mask(i);
        localparam logic [DATA_W-1:0] RST  = (i == DIS_IDX) ? MASK : '0;
        logic [DATA_W-1:0] q;
        // Store masked write data; disable register resets to all ones.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= RST;
            else if (we && addr == ADDR_W'(i * 4)) q <= wdata & MASK;
        end
        assign regs_w[i] = q;
    end

    // Return the addressed register, zero for any unmapped offset.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == ADDR_W'(i * 4)) rdata = regs_w[i];
        end
    end

    assign src_sel  = regs_w[0][SRC_LSB +: SEL_W];
    assign fac_a    = regs_w[1 + DA_REG][DA_LSB +: FLD_W];
    assign fac_b    = regs_w[1 + DB_REG][DB_LSB +: FLD_W];
    assign bypass   = regs_w[4][BYP_BIT];
    assign gate_dis = regs_w[DIS_IDX][DIS_BIT];
endmodule

// File: rtl/ckgen_srcmux.sv
// Source selector: passes the enable pulse of the chosen source.
// Assumes the select is already held stable over a period by the divider.
module ckgen_srcmux #(
    parameter int NSRC  = 4,
    parameter int SEL_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  src_ce,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);
    // Pick one source pulse.
    assign pulse = src_ce[sel];
endmodule

// File: rtl/ckgen_divchain.sv
// Two-factor divider: counts selected source pulses and flags the last
// pulse of each period. Select and ratio are taken from the programmed
// values only while the count is zero, otherwise from a held copy.
// Assumes a zero ratio means stall.
module ckgen_divchain
    import ckgen_pkg::*;
#(
    parameter int SEL_W = 2,
    parameter int CNT_W = 2 * FLD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] prog_sel,
    input  logic [FLD_W-1:0] prog_a,
    input  logic [FLD_W-1:0] prog_b,
    input  logic             prog_byp,
    input  logic             pulse,
    output logic [SEL_W-1:0] eff_sel,
    output logic [CNT_W-1:0] eff_ratio,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q, held_ratio, prog_ratio;
    logic [SEL_W-1:0] held_sel;
    logic             at_edge;

    // Programmed ratio: bypass gives 1, else product of decoded factors.
    assign prog_ratio = prog_byp ? CNT_W'(1)
                      : CNT_W'(factor_of(prog_a)) * CNT_W'(factor_of(prog_b));
    assign at_edge   = (cnt_q == '0);
    assign eff_sel   = at_edge ? prog_sel   : held_sel;
    assign eff_ratio = at_edge ? prog_ratio : held_ratio;
    assign hit       = pulse && (eff_ratio != '0) && (cnt_q == eff_ratio - CNT_W'(1));
    assign cnt_o     = cnt_q;

    // Advance the pulse count and hold the settings of the running period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            held_ratio <= '0;
            held_sel   <= '0;
        end else begin
            held_ratio <= eff_ratio;
            held_sel   <= eff_sel;
            if (pulse && eff_ratio != '0) cnt_q <= hit ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ckgen_gate.sv
// Output gate: registers the divider terminal flag unless disabled.
// Assumes disable is a level from the register bank.
module ckgen_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic gate_dis,
    output logic strobe_o
);
    // Register the gated strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_o <= 1'b0;
        else        strobe_o <= hit && !gate_dis;
    end
endmodule

// File: rtl/clkdiv_gen.sv
// Top: register bank, source selector, two-factor divider and gate.
// Assumes all source enables are synchronous to clk.
module clkdiv_gen
    import ckgen_pkg::*;
#(
    parameter int NSRC    = 4,
    parameter int ADDR_W  = 5,
    parameter int SRC_LSB = 4,
    parameter int DA_REG  = 2,
    parameter int DA_LSB  = 16,
    parameter int DB_REG  = 2,
    parameter int DB_LSB  = 13,
    parameter int BYP_BIT = 7,
    parameter int DIS_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_ce,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              strobe_o
);
    localparam int SEL_W = $clog2(NSRC);
    localparam int CNT_W = 2 * FLD_W;

    logic [SEL_W-1:0] prog_sel, eff_sel;
    logic [FLD_W-1:0] fac_a, fac_b;
    logic             bypass, gate_dis, sel_pulse, div_hit;
    logic [CNT_W-1:0] eff_ratio, div_cnt;

    ckgen_regs #(
        .ADDR_W(ADDR_W), .SEL_W(SEL_W), .SRC_LSB(SRC_LSB),
        .DA_REG(DA_REG), .DA_LSB(DA_LSB), .DB_REG(DB_REG), .DB_LSB(DB_LSB),
        .BYP_BIT(BYP_BIT), .DIS_BIT(DIS_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .src_sel(prog_sel),
        .fac_a(fac_a), .fac_b(fac_b), .bypass(bypass), .gate_dis(gate_dis)
    );

    ckgen_srcmux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
        .src_ce(src_ce), .sel(eff_sel), .pulse(sel_pulse)
    );

    ckgen_divchain #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .prog_sel(prog_sel), .prog_a(fac_a),
        .prog_b(fac_b), .prog_byp(bypass), .pulse(sel_pulse),
        .eff_sel(eff_sel), .eff_ratio(eff_ratio), .cnt_o(div_cnt), .hit(div_hit)
    );

    ckgen_gate u_gate (
        .clk(clk), .rst_n(rst_n), .hit(div_hit), .gate_dis(gate_dis),
        .strobe_o(strobe_o)
    );
endmodule

// File: rtl/clkdiv_gen_chk.sv
// Property checker for clkdiv_gen, attached by bind below.
module clkdiv_gen_chk #(
    parameter int NSRC  = 4,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  src_ce,
    input logic             gate_dis,
    input logic [CNT_W-1:0] eff_ratio,
    input logic [CNT_W-1:0] div_cnt,
    input logic             strobe_o
);
    // R6
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_dis |=> !strobe_o);
    // R9
    no_src_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|src_ce) |=> !strobe_o);
    // R5
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_ratio == '0) |=> !strobe_o);
    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_cnt != '0) |-> (div_cnt < eff_ratio));
    // R8
    period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_cnt != '0) |-> $stable(eff_ratio));
endmodule

bind clkdiv_gen clkdiv_gen_chk #(.NSRC(NSRC), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_ce(src_ce), .gate_dis(gate_dis),
    .eff_ratio(eff_ratio), .div_cnt(div_cnt), .strobe_o(strobe_o)
);

// File: tb/clkdiv_gen_test.sv
module clkdiv_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_ce = '0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        strobe_o;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;
    logic [7:0] lfsr = 8'h5A;

    // behavioural model state
    int p_sel = 0, p_a = 0, p_b = 0, p_byp = 0, p_dis = 1;
    int m_cnt = 0, m_sel = 0, m_ratio = 0;
    bit m_strobe = 0;

    clkdiv_gen uut (.clk(clk), .rst_n(rst_n), .src_ce(src_ce), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .strobe_o(strobe_o));

    always #2.5 clk = ~clk;

    function automatic int fval(input int v);
        return (v == 7) ? 0 : v;
    endfunction

    // source patterns: every cycle, every 2nd, every 3rd, pseudo-random
    always @(negedge clk) begin
        cyc++;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        src_ce <= {lfsr[0], (cyc % 3) == 0, (cyc % 2) == 0, 1'b1};
    end

    // reference model, updated on each rising edge from pre-edge inputs
    always @(posedge clk) begin
        int es, er;
        bit pl, hitm;
        if (!rst_n) begin
            p_sel = 0; p_a = 0; p_b = 0; p_byp = 0; p_dis = 1;
            m_cnt = 0; m_sel = 0; m_ratio = 0; m_strobe = 0;
        end else begin
            if (m_cnt == 0) begin
                es = p_sel;
                er = p_byp ? 1 : fval(p_a) * fval(p_b);
            end else begin
                es = m_sel; er = m_ratio;
            end
            pl = src_ce[es];
            hitm = pl && er != 0 && m_cnt == er - 1;
            m_strobe = hitm && !p_dis;
            if (pl && er != 0) m_cnt = hitm ? 0 : m_cnt + 1;
            m_sel = es; m_ratio = er;
            if (bus_we) begin
                case (bus_addr)
                    5'h00: p_sel = int'(bus_wdata[5:4]);
                    5'h0C: begin p_a = int'(bus_wdata[18:16]); p_b = int'(bus_wdata[15:13]); end
                    5'h10: p_byp = int'(bus_wdata[7]);
                    5'h14: p_dis = int'(bus_wdata[5]);
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the model (R4, R8, R9)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (strobe_o !== m_strobe) begin
                failures++;
                $display("FAIL R9 cycle %0d strobe actual=%0b expected=%0b", cyc, strobe_o, m_strobe);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input int exp, input string tag);
        bus_addr = a;
        #1;
        check(tag, int'(bus_rdata), exp);
    endtask

    task automatic wait_strobe();
        int n = 0;
        while (!strobe_o && n < 500) begin @(negedge clk); n++; end
    endtask

    task automatic next_gap(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!strobe_o && n < 500);
    endtask

    task automatic gap_check(input int exp, input string tag);
        int n;
        repeat (40) @(negedge clk);
        wait_strobe();
        next_gap(n);
        check(tag, n, exp);
    endtask

    task automatic count_window(input int len, output int n);
        n = 0;
        for (int i = 0; i < len; i++) begin @(negedge clk); if (strobe_o) n++; end
    endtask

    task automatic set_div(input int a, input int b);
        wr(5'h0C, (32'(a) << 16) | (32'(b) << 13));
    endtask

    initial begin
        int n;
        repeat (5) @(negedge clk);
        check("R2 strobe low in reset", int'(strobe_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 strobe low after reset", int'(strobe_o), 0);
        rd(5'h00, 0, "R2 src reset"); rd(5'h04, 0, "R2 div0 reset");
        rd(5'h08, 0, "R2 div1 reset"); rd(5'h0C, 0, "R2 div2 reset");
        rd(5'h10, 0, "R2 bypass reset"); rd(5'h14, 32'h20, "R2 disable reset");
        // R1 all-ones readback
        for (int i = 0; i < 6; i++) wr(5'(i * 4), 32'hFFFF_FFFF);
        rd(5'h00, 32'h30, "R1 src mask"); rd(5'h04, 0, "R1 div0 mask");
        rd(5'h08, 0, "R1 div1 mask"); rd(5'h0C, 32'h7E000, "R1 div2 mask");
        rd(5'h10, 32'h80, "R1 bypass mask"); rd(5'h14, 32'h20, "R1 disable mask");
        rd(5'h18, 0, "R1 unmapped");
        for (int i = 0; i < 6; i++) wr(5'(i * 4), 32'h0);
        // R4 product ratio on every-cycle source
        wr(5'h00, 32'h00); set_div(3, 2);
        gap_check(6, "R4 ratio 3*2 gap");
        // R3 same ratio on the every-2nd source doubles the gap
        wr(5'h00, 32'h10);
        gap_check(12, "R3 sel1 gap");
        wr(5'h00, 32'h20); set_div(2, 1);
        gap_check(6, "R3 sel2 ratio 2 gap");
        // R7 bypass
        wr(5'h10, 32'h80);
        gap_check(3, "R7 bypass sel2 gap");
        wr(5'h10, 32'h0);
        wr(5'h00, 32'h00); set_div(1, 1);
        gap_check(1, "R4 ratio 1 gap");
        // R5 invalid and zero factors
        set_div(7, 2); repeat (50) @(negedge clk);
        count_window(100, n); check("R5 factor 7 stalls", n, 0);
        set_div(0, 5); repeat (50) @(negedge clk);
        count_window(100, n); check("R5 factor 0 stalls", n, 0);
        // R6 gate
        set_div(2, 1); wr(5'h14, 32'h20); repeat (10) @(negedge clk);
        count_window(50, n); check("R6 disabled no strobe", n, 0);
        wr(5'h14, 32'h0);
        gap_check(2, "R6 re-enabled gap");
        // R8 deferred update
        set_div(3, 2); repeat (40) @(negedge clk);
        wait_strobe();
        set_div(1, 1);
        next_gap(n); check("R8 old period completes", n + 1, 6);
        next_gap(n); check("R8 new ratio applied", n, 1);
        // random source run, compared cycle by cycle
        wr(5'h00, 32'h30); set_div(2, 2);
        repeat (200) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule